// File: doc/BRIEF.md
# Infrared Receive Byte Buffer with Interrupt Flags

This block sits behind an infrared pulse sampler. Each cycle the sampler may hand over one run-length byte (a level bit and a duration), and at the end of a burst it pulses a packet-end signal. The bytes are held in a first-in first-out store. A host reaches that store, an interrupt-enable register and a status register through a plain read/write strobe interface. Each register has a two-bit word address.

The status word packs three sticky pending flags into its low byte, with the live byte count above them. The flags are overflow, packet end and data available. The data-available flag fires once the fill passes a programmable trigger level held in the enable register. Software normally sets that level to half the depth minus one, so that it drains the store in batches. A single interrupt line is the OR of the pending flags whose enable bit is set.

Word addresses: 0 data (read pops), 1 interrupt enable, 2 status, 3 reads as zero. Flag positions are the same in the enable and status words: bit 0 overflow, bit 1 packet end, bit 4 data available. The default depth is 16, which gives a 5-bit count field and a 4-bit level field.

Top module: `ir_rx_capture`

## Requirements
- R1: After reset the byte count is 0, all pending flags are clear, the enable register reads 0 and `irq` is low.
- R2: A read of address 0 returns the oldest stored byte in bits 7:0, with bits 31:8 zero, and removes that byte. Bytes come out in arrival order.
- R3: A byte offered while the store holds DEPTH bytes is dropped and sets status bit 0 (overflow). The count stays at DEPTH, and the dropped byte is never returned.
- R4: A one-cycle pulse on `smp_pkt_end` sets status bit 1 (packet end).
- R5: Status bit 4 (data available) sets whenever the count is greater than the trigger level held in enable bits 8 and up.
- R6: Status bits 8 and up hold the current byte count in a field of clog2(DEPTH)+1 bits, wide enough for 2*DEPTH-1.
- R7: Writing the status word clears each pending flag whose bit is 1 and leaves those written 0. When a set condition occurs in the same cycle as its clear, the set wins.
- R8: A read of address 0 while the store is empty returns 0 and leaves the count at 0.
- R9: `irq` is high exactly when some pending flag has its enable bit set (bit 0 overflow, bit 1 packet end, bit 4 data available).
- R10: The enable register reads back bits 0, 1 and 4 and the level field as written, with every other bit zero.
- R11: A write to address 0 changes neither the stored bytes nor the count.
- R12: `bus_rdata` takes the value of a read one clock after the cycle in which `bus_rd` is sampled high, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sampler byte strobe |
| smp_byte | input | 8 | Run-length byte from the sampler |
| smp_pkt_end | input | 1 | End-of-burst pulse from the sampler |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the store to exactly DEPTH and then offers one more byte. A design with an off-by-one full test would keep that byte and return it as a seventeenth read, or would fail to flag the overflow. It clears the data-available flag while the fill is still above the level, which catches a design that lets the clear win over the standing set condition. It steps the fill across the trigger level, so a design that compares with greater-or-equal would flag one byte early. It also reads from the empty store and writes to the data address, which exposes a design that underflows its pointers or accepts bus data into the store.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_IEN  = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // bit positions shared by the enable and status words
    localparam int BIT_OVF   = 0;
    localparam int BIT_PKT   = 1;
    localparam int BIT_AVL   = 4;
    localparam int FIELD_LSB = 8;

    // index of each flag inside the internal 3-bit pending vector
    localparam int IX_OVF = 0;
    localparam int IX_PKT = 1;
    localparam int IX_AVL = 2;
    localparam int NFLAG  = 3;
endpackage

// File: rtl/ir_rx_store.sv
module ir_rx_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [DW-1:0]    data_i,
    input  logic             pop_i,
    output logic [DW-1:0]    head_o,
    output logic [CNT_W-1:0] count_o,
    output logic             empty_o,
    output logic             dropped_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PTR_W-1:0]         wr;
        logic [PTR_W-1:0]         rd;
        logic [CNT_W-1:0]         cnt;
    } store_t;

    store_t s_d, s_q;
    logic   take, give;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign take = push_i && (s_q.cnt != FULL_CNT);
    assign give = pop_i && (s_q.cnt != '0);

    always_comb begin
        s_d = s_q;
        if (take) begin
            s_d.mem[s_q.wr] = data_i;
            s_d.wr          = step(s_q.wr);
        end
        if (give) begin
            s_d.rd = step(s_q.rd);
        end
        s_d.cnt = s_q.cnt + CNT_W'(take) - CNT_W'(give);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head_o    = s_q.mem[s_q.rd];
    assign count_o   = s_q.cnt;
    assign empty_o   = (s_q.cnt == '0);
    assign dropped_o = push_i && !take;

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= FULL_CNT)
        else $error("R3 count exceeds depth");

    p_drop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && (s_q.cnt == FULL_CNT) && !pop_i) |=> (s_q.cnt == FULL_CNT))
        else $error("R3 full store accepted a byte");

    p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && (s_q.cnt == '0) && !push_i) |=> (s_q.cnt == '0))
        else $error("R8 empty pop changed count");
endmodule

// File: rtl/ir_rx_flags.sv
module ir_rx_flags
    import ir_rx_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drop_i,
    input  logic             pkt_end_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [NFLAG-1:0] clr_i,
    input  logic [NFLAG-1:0] en_i,
    output logic [NFLAG-1:0] pend_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [NFLAG-1:0] pend;
    } flag_t;

    flag_t            f_d, f_q;
    logic [NFLAG-1:0] set_v;

    always_comb begin
        set_v         = '0;
        set_v[IX_OVF] = drop_i;
        set_v[IX_PKT] = pkt_end_i;
        set_v[IX_AVL] = (count_i > CNT_W'(level_i));
        f_d           = f_q;
        // a set event outranks a clear arriving in the same cycle
        f_d.pend      = (f_q.pend & ~clr_i) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign pend_o = f_q.pend;
    assign irq_o  = |(f_q.pend & en_i);

    p_pkt_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end_i |=> f_q.pend[IX_PKT])
        else $error("R4 packet end not flagged");

    p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        drop_i |=> f_q.pend[IX_OVF])
        else $error("R3 drop not flagged");

    p_avl_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i > CNT_W'(level_i)) |=> f_q.pend[IX_AVL])
        else $error("R5 level crossing not flagged");

    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[IX_PKT] && !pkt_end_i) |=> !f_q.pend[IX_PKT])
        else $error("R7 clear did not take");
endmodule

// File: rtl/ir_rx_capture.sv
module ir_rx_capture
    import ir_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_byte,
    input  logic          smp_pkt_end,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          irq
);
    localparam int CNT_W = $clog2(DEPTH) + 1;
    localparam int LVL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [NFLAG-1:0] en;
        logic [LVL_W-1:0] level;
        logic [31:0]      rdata;
    } regs_t;

    regs_t            r_d, r_q;
    reg_sel_e         sel;
    logic             pop;
    logic [DW-1:0]    head;
    logic [CNT_W-1:0] count;
    logic             empty, dropped;
    logic [NFLAG-1:0] clr, pend;
    logic [31:0]      ien_word, stat_word;
    logic             wdata_unused;

    assign sel          = reg_sel_e'(bus_addr);
    assign pop          = bus_rd && (sel == REG_DATA);
    assign wdata_unused = ^bus_wdata;

    ir_rx_store #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (smp_valid),
        .data_i    (smp_byte),
        .pop_i     (pop),
        .head_o    (head),
        .count_o   (count),
        .empty_o   (empty),
        .dropped_o (dropped)
    );

    always_comb begin
        clr = '0;
        if (bus_wr && (sel == REG_STAT)) begin
            clr[IX_OVF] = bus_wdata[BIT_OVF];
            clr[IX_PKT] = bus_wdata[BIT_PKT];
            clr[IX_AVL] = bus_wdata[BIT_AVL];
        end
    end

    ir_rx_flags #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .drop_i    (dropped),
        .pkt_end_i (smp_pkt_end),
        .count_i   (count),
        .level_i   (r_q.level),
        .clr_i     (clr),
        .en_i      (r_q.en),
        .pend_o    (pend),
        .irq_o     (irq)
    );

    always_comb begin
        ien_word                        = '0;
        ien_word[BIT_OVF]               = r_q.en[IX_OVF];
        ien_word[BIT_PKT]               = r_q.en[IX_PKT];
        ien_word[BIT_AVL]               = r_q.en[IX_AVL];
        ien_word[FIELD_LSB +: LVL_W]    = r_q.level;
        stat_word                       = '0;
        stat_word[BIT_OVF]              = pend[IX_OVF];
        stat_word[BIT_PKT]              = pend[IX_PKT];
        stat_word[BIT_AVL]              = pend[IX_AVL];
        stat_word[FIELD_LSB +: CNT_W]   = count;
    end

    always_comb begin
        r_d = r_q;
        if (bus_wr && (sel == REG_IEN)) begin
            r_d.en[IX_OVF] = bus_wdata[BIT_OVF];
            r_d.en[IX_PKT] = bus_wdata[BIT_PKT];
            r_d.en[IX_AVL] = bus_wdata[BIT_AVL];
            r_d.level      = bus_wdata[FIELD_LSB +: LVL_W];
        end
        if (bus_rd) begin
            unique case (sel)
                REG_DATA: r_d.rdata = empty ? '0 : 32'(head);
                REG_IEN:  r_d.rdata = ien_word;
                REG_STAT: r_d.rdata = stat_word;
                default:  r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;

    p_empty_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> (bus_rdata == '0))
        else $error("R8 empty read returned data");

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata))
        else $error("R12 read data moved without a read");
endmodule

// File: tb/ir_rx_capture_bench.sv
`timescale 1ns/1ps
module ir_rx_capture_bench;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [7:0]  smp_byte = '0;
    logic        smp_pkt_end = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0]  model_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #4 clk = ~clk;

    ir_rx_capture #(.DEPTH(DEPTH)) u_ir_rx_capture (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_byte(smp_byte),
        .smp_pkt_end(smp_pkt_end), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares each read result one clock after its strobe (R12)
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, bus_rdata, e);
        end
    end

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_byte  = b;
        if (model_q.size() < DEPTH) model_q.push_back(b);
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic reg_read(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_byte(input string tag);
        logic [31:0] e;
        e = (model_q.size() > 0) ? 32'(model_q.pop_front()) : 32'h0;
        reg_read(2'd0, e, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", 32'(irq), 32'h0);
        reg_read(2'd2, 32'h0, "R1 status");
        reg_read(2'd1, 32'h0, "R1 enable");
        reg_read(2'd3, 32'h0, "R1 unused address");

        // R10 enable readback, only defined fields
        reg_write(2'd1, 32'hFFFF_FFFF);
        reg_read(2'd1, 32'h0000_0F13, "R10 enable all ones");
        reg_write(2'd1, 32'h0000_0310);
        reg_read(2'd1, 32'h0000_0310, "R10 enable level 3");

        // R5/R6 fill up to the level, no flag yet
        push_byte(8'hA1); push_byte(8'hA2); push_byte(8'hA3);
        reg_read(2'd2, 32'h0000_0300, "R6 count 3 no avail R5");
        check("R9 irq below level", 32'(irq), 32'h0);
        push_byte(8'hA4);
        check("R9 irq above level", 32'(irq), 32'h1);
        reg_read(2'd2, 32'h0000_0410, "R5 count 4 avail");

        // R11 data address write ignored
        reg_write(2'd0, 32'h0000_00FF);
        reg_read(2'd2, 32'h0000_0410, "R11 data write ignored");

        // R2 order
        read_byte("R2 first byte");
        read_byte("R2 second byte");
        reg_read(2'd2, 32'h0000_0210, "R5 sticky after drain");
        reg_write(2'd2, 32'h0000_0000);
        reg_read(2'd2, 32'h0000_0210, "R7 zero write keeps flag");
        reg_write(2'd2, 32'h0000_0010);
        reg_read(2'd2, 32'h0000_0200, "R7 clear avail");
        check("R9 irq after clear", 32'(irq), 32'h0);
        read_byte("R2 third byte");
        read_byte("R2 fourth byte");
        read_byte("R8 empty read zero");
        reg_read(2'd2, 32'h0000_0000, "R8 count stays 0");

        // R4 packet end
        @(negedge clk); smp_pkt_end = 1'b1;
        @(negedge clk); smp_pkt_end = 1'b0;
        @(negedge clk);
        reg_read(2'd2, 32'h0000_0002, "R4 packet end flag");
        check("R9 irq pkt masked", 32'(irq), 32'h0);
        reg_write(2'd1, 32'h0000_0302);
        check("R9 irq pkt enabled", 32'(irq), 32'h1);
        reg_write(2'd2, 32'h0000_0002);
        check("R7 irq after pkt clear", 32'(irq), 32'h0);

        // R3 overflow at exactly DEPTH
        reg_write(2'd1, 32'h0000_0301);
        for (int i = 0; i < DEPTH; i++) push_byte(8'hB0 + 8'(i));
        reg_read(2'd2, 32'h0000_1010, "R6 full count no overflow");
        check("R9 irq before overflow", 32'(irq), 32'h0);
        push_byte(8'hEE);
        reg_read(2'd2, 32'h0000_1011, "R3 overflow flag");
        check("R3 irq overflow", 32'(irq), 32'h1);
        reg_write(2'd2, 32'h0000_0010);
        reg_read(2'd2, 32'h0000_1011, "R7 set wins over clear");
        reg_write(2'd2, 32'h0000_0001);
        check("R7 irq after ovf clear", 32'(irq), 32'h0);
        for (int i = 0; i < DEPTH; i++) read_byte("R3 drain order");
        read_byte("R3 dropped byte absent");
        reg_read(2'd2, 32'h0000_0010, "R6 count zero after drain");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule